// File: doc/BRIEF.md
# Sample Streamer Over Serial Peripheral Interface

This block sits between an on-chip sample FIFO and an external host. The host supplies the serial clock and the block supplies the data. The select line is turned around and driven by the block, so it acts as a ready flag. It goes low once enough 16-bit samples are buffered to fill one burst. A burst is a fixed number of frames, each holding one word per channel, and with the default settings it carries one millisecond of data. The host answers by clocking out exactly one burst, then waits for the flag to fall again.

The incoming serial clock is about 9 MHz. It passes through a two-stage synchronizer into the much faster system clock, and only its rising edges are used. On each rising edge the next data bit is launched, most significant bit first, with words taken in FIFO order. Because of the input delay, the output changes well before the host samples on the falling edge. The FIFO takes one cycle to return read data, so the next word is prefetched into a holding register long before it is needed.

If the serial clock stays quiet for a set number of system cycles, the bit and word position go back to the start of a word and a burst. A slipped bit therefore lasts no longer than one burst. If a word has to start while nothing is buffered, zeros are sent and a sticky error flag is raised.

Top module: `sstream_top`

## Requirements
- R1: While reset is held low and right after it, ready_n is 1, sdo is 0, underrun is 0 and fifo_rd_en is 0.
- R2: Outside a burst, ready_n is 0 exactly when the buffered word count (FIFO count plus any prefetched word) is at least CHANNELS*FRAMES. The flag is updated on the clock edge after the count changes.
- R3: The first registered serial-clock rising edge of a burst drives ready_n to 1 on that same system edge. ready_n stays 1 until the burst ends.
- R4: Each rising edge of sclk_in shows up on sdo three system clocks later, after two synchronizer stages and the edge register. Words go out most significant bit first, in FIFO order.
- R5: A burst ends after exactly CHANNELS*FRAMES words of DATA_W bits. The ready condition of R2 is then checked again, so a new burst can be offered.
- R6: When no serial-clock rising edge arrives for IDLE_CYCLES system clocks, the bit and word position return to zero and any burst in progress is dropped. The next rising edge starts a fresh word at its most significant bit and a fresh burst.
- R7: The FIFO is read only when it is not empty, with at most one read outstanding. The word returned one cycle later is held until a word start uses it.
- R8: A word that starts with nothing buffered is sent as all zeros and sets underrun. underrun stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_in | input | 1 | Serial clock from the host, asynchronous to clk |
| fifo_count | input | CNT_W | Number of words currently in the sample FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rd_data | input | DATA_W | FIFO read data, valid one cycle after fifo_rd_en |
| fifo_rd_en | output | 1 | FIFO read request |
| sdo | output | 1 | Serial data to the host |
| ready_n | output | 1 | Ready flag on the select line, low when a burst is available |
| underrun | output | 1 | Sticky flag: a word was sent with no data buffered |

## Verification
The checks assume that fifo_count and fifo_empty agree with each other and describe a FIFO whose read data arrives one cycle after the request. They also assume that serial-clock rising edges are many system cycles apart and that fifo_count changes only with the block's own reads or the producer's writes. The stimulus uses a FIFO model that follows exactly that read timing. It holds each serial-clock level for 14 system clocks and writes new words only while the serial clock is idle, so a prefetch always finishes before the next word starts, except in the deliberate underrun case. The idle realignment is exercised by stopping in the middle of a word for longer than IDLE_CYCLES.

// File: rtl/sstream_pkg.sv
package sstream_pkg;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_BURST = 1'b1
    } phase_e;

endpackage

// File: rtl/sstream_sync.sv
module sstream_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    output logic rise_o
);
    // chain[STAGES-1] is the last synchronizer flop, chain[STAGES] its delayed copy
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], sclk_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/sstream_prefetch.sv
module sstream_prefetch #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_rd_data,
    output logic              fifo_rd_en,
    input  logic              take_i,
    output logic [DATA_W-1:0] next_word_o,
    output logic              next_vld_o,
    output logic [CNT_W:0]    level_o
);
    typedef struct packed {
        logic              pend;
        logic              vld;
        logic [DATA_W-1:0] word;
    } pf_t;

    pf_t s_d, s_q;
    logic rd;

    always_comb begin
        s_d = s_q;
        rd  = 1'b0;
        if (take_i) s_d.vld = 1'b0;
        if (s_q.pend) begin
            s_d.pend = 1'b0;
            s_d.vld  = 1'b1;
            s_d.word = fifo_rd_data;
        end else if (!s_q.vld && !fifo_empty) begin
            rd       = 1'b1;
            s_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fifo_rd_en  = rd;
    assign next_word_o = s_q.word;
    assign next_vld_o  = s_q.vld;
    assign level_o     = {1'b0, fifo_count} + (CNT_W+1)'(s_q.pend) + (CNT_W+1)'(s_q.vld);

endmodule

// File: rtl/sstream_framer.sv
module sstream_framer
    import sstream_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int BURST_WORDS = 384,
    parameter int IDLE_CYCLES = 64,
    parameter int LVL_W       = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic [DATA_W-1:0] next_word_i,
    input  logic              next_vld_i,
    input  logic [LVL_W-1:0]  level_i,
    output logic              take_o,
    output logic              sdo_o,
    output logic              ready_n_o,
    output logic              underrun_o
);
    localparam int BIT_W  = $clog2(DATA_W);
    localparam int WORD_W = $clog2(BURST_WORDS);
    localparam int IDLE_W = $clog2(IDLE_CYCLES + 1);

    typedef struct packed {
        phase_e             phase;
        logic [BIT_W-1:0]   bitc;
        logic [WORD_W-1:0]  wordc;
        logic [IDLE_W-1:0]  idle;
        logic [DATA_W-1:0]  shreg;
        logic               sdo;
        logic               rdy_n;
        logic               under;
    } fr_t;

    localparam fr_t FR_RST = '{phase: PH_IDLE, bitc: '0, wordc: '0, idle: '0,
                               shreg: '0, sdo: 1'b0, rdy_n: 1'b1, under: 1'b0};

    fr_t s_d, s_q;
    logic [DATA_W-1:0] start_word;

    always_comb begin
        s_d        = s_q;
        take_o     = 1'b0;
        start_word = '0;
        if (rise_i) begin
            s_d.idle  = '0;
            s_d.phase = PH_BURST;
            if (s_q.bitc == '0) begin
                start_word = next_vld_i ? next_word_i : '0;
                take_o     = next_vld_i;
                if (!next_vld_i) s_d.under = 1'b1;
                s_d.sdo   = start_word[DATA_W-1];
                s_d.shreg = start_word << 1;
            end else begin
                s_d.sdo   = s_q.shreg[DATA_W-1];
                s_d.shreg = s_q.shreg << 1;
            end
            if (s_q.bitc == BIT_W'(DATA_W - 1)) begin
                s_d.bitc = '0;
                if (s_q.wordc == WORD_W'(BURST_WORDS - 1)) begin
                    s_d.wordc = '0;
                    s_d.phase = PH_IDLE;
                end else begin
                    s_d.wordc = s_q.wordc + 1'b1;
                end
            end else begin
                s_d.bitc = s_q.bitc + 1'b1;
            end
        end else begin
            if (s_q.idle != IDLE_W'(IDLE_CYCLES)) s_d.idle = s_q.idle + 1'b1;
            if (s_q.idle == IDLE_W'(IDLE_CYCLES - 1)) begin
                s_d.bitc  = '0;
                s_d.wordc = '0;
                s_d.phase = PH_IDLE;
            end
        end
        s_d.rdy_n = !((s_d.phase == PH_IDLE) && (level_i >= LVL_W'(BURST_WORDS)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= FR_RST;
        else        s_q <= s_d;
    end

    assign sdo_o      = s_q.sdo;
    assign ready_n_o  = s_q.rdy_n;
    assign underrun_o = s_q.under;

endmodule

// File: rtl/sstream_top.sv
module sstream_top #(
    parameter int DATA_W      = 16,
    parameter int CHANNELS    = 8,
    parameter int FRAMES      = 48,
    parameter int IDLE_CYCLES = 64,
    parameter int CNT_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_rd_data,
    output logic              fifo_rd_en,
    output logic              sdo,
    output logic              ready_n,
    output logic              underrun
);
    localparam int BURST_WORDS = CHANNELS * FRAMES;
    localparam int LVL_W       = CNT_W + 1;

    logic              rise_w;
    logic              take_w;
    logic [DATA_W-1:0] next_word_w;
    logic              next_vld_w;
    logic [LVL_W-1:0]  level_w;

    sstream_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_in (sclk_in),
        .rise_o  (rise_w)
    );

    sstream_prefetch #(.DATA_W(DATA_W), .CNT_W(CNT_W)) pf_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_count   (fifo_count),
        .fifo_empty   (fifo_empty),
        .fifo_rd_data (fifo_rd_data),
        .fifo_rd_en   (fifo_rd_en),
        .take_i       (take_w),
        .next_word_o  (next_word_w),
        .next_vld_o   (next_vld_w),
        .level_o      (level_w)
    );

    sstream_framer #(
        .DATA_W      (DATA_W),
        .BURST_WORDS (BURST_WORDS),
        .IDLE_CYCLES (IDLE_CYCLES),
        .LVL_W       (LVL_W)
    ) fr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise_w),
        .next_word_i (next_word_w),
        .next_vld_i  (next_vld_w),
        .level_i     (level_w),
        .take_o      (take_w),
        .sdo_o       (sdo),
        .ready_n_o   (ready_n),
        .underrun_o  (underrun)
    );

endmodule

// File: rtl/sstream_checker.sv
module sstream_checker #(
    parameter int BURST_WORDS = 384,
    parameter int LVL_W       = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rise,
    input logic             sdo,
    input logic             ready_n,
    input logic             fifo_rd_en,
    input logic             fifo_empty,
    input logic             underrun,
    input logic [LVL_W-1:0] level
);
    assert_rd_not_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |-> !fifo_empty);

    assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |=> !fifo_rd_en);

    assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

    assert_sdo_moves_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rise) |-> $stable(sdo));

    assert_ready_needs_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_n |-> ($past(level) >= LVL_W'(BURST_WORDS)));

    assert_ready_drops_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_n && rise) |=> ready_n);

endmodule

bind sstream_top sstream_checker #(
    .BURST_WORDS (BURST_WORDS),
    .LVL_W       (LVL_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise       (rise_w),
    .sdo        (sdo),
    .ready_n    (ready_n),
    .fifo_rd_en (fifo_rd_en),
    .fifo_empty (fifo_empty),
    .underrun   (underrun),
    .level      (level_w)
);

// File: tb/sstream_top_tb_top.sv
`timescale 1ns/1ps
module sstream_top_tb_top;
    localparam int DW    = 16;
    localparam int CH    = 8;
    localparam int FR    = 2;
    localparam int IDLE  = 64;
    localparam int CW    = 10;
    localparam int BURST = CH * FR;
    localparam int HALF  = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic [CW-1:0] fifo_count = '0;
    logic fifo_empty;
    logic [DW-1:0] fifo_rd_data = '0;
    logic fifo_rd_en, sdo, ready_n, underrun;

    always #2 clk = ~clk;

    assign fifo_empty = (fifo_count == '0);

    sstream_top #(.DATA_W(DW), .CHANNELS(CH), .FRAMES(FR), .IDLE_CYCLES(IDLE), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .fifo_count(fifo_count),
        .fifo_empty(fifo_empty), .fifo_rd_data(fifo_rd_data), .fifo_rd_en(fifo_rd_en),
        .sdo(sdo), .ready_n(ready_n), .underrun(underrun));

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // FIFO model and behavioural reference, both updated on the rising edge
    logic [DW-1:0] fq[$];
    logic [DW-1:0] mq[$];
    logic wr_req = 1'b0;
    logic [DW-1:0] wr_word = '0;
    bit m1, m2, m3, mburst, msdo, mready_n, munder;
    int mbit, mword, midle, lvl;
    logic [DW-1:0] mcur;

    always @(posedge clk) begin
        if (!rst_n) begin
            m1 = 0; m2 = 0; m3 = 0; mburst = 0; msdo = 0; mready_n = 1; munder = 0;
            mbit = 0; mword = 0; midle = 0; mcur = '0;
        end else begin
            lvl = mq.size();
            if (fifo_rd_en) begin
                if (fq.size() > 0) fifo_rd_data <= fq.pop_front();
                else check(1'b0, "R7 read while empty", 1, 0);
            end
            if (m2 && !m3) begin
                midle = 0;
                mburst = 1;
                if (mbit == 0) begin
                    if (mq.size() > 0) mcur = mq.pop_front();
                    else begin mcur = '0; munder = 1; end
                end
                msdo = mcur[DW-1-mbit];
                if (mbit == DW-1) begin
                    mbit = 0;
                    if (mword == BURST-1) begin mword = 0; mburst = 0; end
                    else mword++;
                end else mbit++;
            end else begin
                if (midle == IDLE-1) begin mbit = 0; mword = 0; mburst = 0; end
                if (midle < IDLE) midle++;
            end
            mready_n = !(!mburst && lvl >= BURST);
            if (wr_req) begin fq.push_back(wr_word); mq.push_back(wr_word); end
            fifo_count <= CW'(fq.size());
            m3 = m2; m2 = m1; m1 = sclk;
        end
    end

    // per-clock comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(sdo == msdo, "R4 sdo vs model", sdo, msdo);
            check(ready_n == mready_n, "R2 ready_n vs model", ready_n, mready_n);
            check(underrun == munder, "R8 underrun vs model", underrun, munder);
        end
    end

    logic [DW-1:0] exp_q[$];

    task automatic push_word(input logic [DW-1:0] w);
        wr_req = 1'b1; wr_word = w; exp_q.push_back(w);
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_word(output logic [DW-1:0] got);
        for (int b = 0; b < DW; b++) begin
            sclk = 1'b1;
            wait_clk(HALF);
            got[DW-1-b] = sdo;
            sclk = 1'b0;
            wait_clk(HALF);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog expired", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] got, exp;
        wait_clk(5);
        check(ready_n == 1'b1, "R1 reset ready_n", ready_n, 1);
        check(sdo == 1'b0, "R1 reset sdo", sdo, 0);
        check(underrun == 1'b0, "R1 reset underrun", underrun, 0);
        check(fifo_rd_en == 1'b0, "R1 reset rd_en", fifo_rd_en, 0);
        rst_n = 1'b1;
        wait_clk(3);
        check(ready_n == 1'b1, "R1 after reset ready_n", ready_n, 1);

        // one word short of a burst, then over the threshold
        for (int i = 0; i < BURST-1; i++) begin
            case (i % 4)
                0: push_word(16'h8001 ^ DW'(i));
                1: push_word(16'hFFFF);
                2: push_word(16'h0000);
                default: push_word(DW'(i * 16'h1357));
            endcase
        end
        wait_clk(6);
        check(ready_n == 1'b1, "R2 below threshold", ready_n, 1);
        for (int i = 0; i < 5; i++) push_word(16'hC3A0 + DW'(i));
        wait_clk(6);
        check(ready_n == 1'b0, "R2 at threshold", ready_n, 0);

        // full burst
        for (int w = 0; w < BURST; w++) begin
            xfer_word(got);
            exp = exp_q.pop_front();
            check(got == exp, "R4 word order and bit order", got, exp);
            if (w == 0) check(ready_n == 1'b1, "R3 ready drops in burst", ready_n, 1);
        end
        wait_clk(6);
        check(ready_n == 1'b1, "R5 burst ended, 4 left", ready_n, 1);
        check(underrun == 1'b0, "R8 no underrun yet", underrun, 0);
        for (int i = 0; i < BURST-4; i++) push_word(16'h5A00 + DW'(i * 3));
        wait_clk(6);
        check(ready_n == 1'b0, "R5 re-evaluated after burst", ready_n, 0);

        // partial word then idle gap: realign
        for (int b = 0; b < 5; b++) begin
            sclk = 1'b1; wait_clk(HALF); sclk = 1'b0; wait_clk(HALF);
        end
        void'(exp_q.pop_front());
        wait_clk(IDLE + 20);
        check(ready_n == 1'b1, "R6 burst dropped, 15 left", ready_n, 1);
        for (int w = 0; w < BURST-1; w++) begin
            xfer_word(got);
            exp = exp_q.pop_front();
            check(got == exp, "R6 realigned word", got, exp);
        end
        xfer_word(got);
        check(got == '0, "R8 zeros on empty", got, 0);
        wait_clk(4);
        check(underrun == 1'b1, "R8 underrun set", underrun, 1);
        check(ready_n == 1'b1, "R5 empty after burst", ready_n, 1);

        for (int i = 0; i < BURST; i++) push_word(16'h0F0F ^ DW'(i << 4));
        wait_clk(6);
        check(ready_n == 1'b0, "R2 refilled", ready_n, 0);
        check(underrun == 1'b1, "R8 underrun sticky", underrun, 1);
        xfer_word(got);
        exp = exp_q.pop_front();
        check(got == exp, "R7 prefetched word after refill", got, exp);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule